// File: doc/BRIEF.md
# Sleep-State Power Rail Sequencer

This block turns the two active-low sleep-request lines of a desktop power system into one of three operating states (running, suspend-to-RAM and soft-off) and from that state drives on/off requests for three power rails. These are a 3.3 V dual rail, a 5 V dual rail and a memory rail. It also drives one enable for the pass devices that connect the main supply to those rails.

The request lines, the two keep-alive enables, the 12 V supply-good flag and the shutdown input arrive asynchronously and are synchronised first. A change on the S3 line starts a validation timer, and the block only acts on what the lines show when the timer runs out. This filters out glitches and tolerates S5 trailing S3 on the way into soft-off. Direct moves between the two sleep states are refused.

Each keep-alive enable decides whether its dual rail stays up in soft-off. The enables are captured at start-up, on release of shutdown and on entry to a sleep state. While running, the rails and the main pass-device enable are held off until the 12 V supply-good flag has been high without a break for a set time. A sleep request that arrives inside that wait sends the block back through its start-up state.

Top module: `acpi_sleep_ctl`

## Requirements
- R1: While `rst` is high, `state_o` is 0 (start-up) and all four rail and enable outputs are 0. After reset the block stays in state 0 until the synchronised request lines form a legal combination. The state codes are 0 start-up, 1 running, 2 suspend-to-RAM and 3 soft-off.
- R2: A state change out of a non-start-up state happens only when the validation timer expires. The timer is FILT_CYC cycles long and starts when the synchronised S3 differs from its last accepted value. Outside start-up, the state therefore cannot change within FILT_CYC cycles of an S3 edge. An S3 pulse that returns before expiry leaves the state unchanged.
- R3: The line combination S3=1 with S5=0 is illegal and never causes a transition. The block keeps its current state.
- R4: There is no transition from suspend-to-RAM to soft-off, and none from soft-off to suspend-to-RAM, whatever the lines show at timer expiry.
- R5: Suppose S3 falls while running and S5 falls before the timer expires. The block then enters soft-off. If S5 falls after the block has entered suspend-to-RAM, it stays in suspend-to-RAM.
- R6: The keep-alive enables are captured while in state 0 and on a transition from running into a sleep state. Changes to them while asleep have no effect on the rail outputs.
- R7: A dual rail output is 1 when running and ready, and 1 in suspend-to-RAM. In soft-off it equals its captured enable: `dual3_on_o` follows `keep3_i` and `dual5_on_o` follows `keep5_i`. In every other case it is 0.
- R8: `mem_on_o` is 1 when running and ready and in suspend-to-RAM, and 0 in soft-off and in start-up.
- R9: When running, ready is reached after PG_CYC consecutive cycles of synchronised `pg12_i` high. Until then `main_sw_en_o` and all rails are 0. `main_sw_en_o` is 1 only when running and ready.
- R10: A validated sleep request while running but not yet ready moves the state to 0 for one cycle and then into the requested sleep state.
- R11: While synchronised `shdn_i` is high, the state is 0 and all outputs are 0. On its release the enables are captured again and the block enters the state the lines select, so soft-off can be entered directly with the new enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slp3_n_i | input | 1 | Suspend-to-RAM request, active low, asynchronous |
| slp5_n_i | input | 1 | Soft-off request, active low, asynchronous |
| keep3_i | input | 1 | Keep 3.3 V dual rail up in soft-off |
| keep5_i | input | 1 | Keep 5 V dual rail up in soft-off |
| pg12_i | input | 1 | 12 V supply good |
| shdn_i | input | 1 | Shutdown: force start-up state, all outputs off |
| state_o | output | 2 | Operating state code |
| main_sw_en_o | output | 1 | Main-supply pass-device enable |
| dual3_on_o | output | 1 | 3.3 V dual rail request |
| dual5_on_o | output | 1 | 5 V dual rail request |
| mem_on_o | output | 1 | Memory rail request |

## Verification
The hardest situation to reach is a sleep-to-sleep request at timer expiry. In normal operation S3 is already low in both sleep states, so the only way to expose the block is an S3 pulse after S5 has moved. The bench enters suspend-to-RAM, lowers S5, then pulses S3 high for a few cycles so the timer expires on a soft-off pattern. It mirrors the same sequence from soft-off. The early-request reset (R10) is reached by entering the running state with the 12 V flag held low and then dropping S3, while a monitor records whether state 0 appears.

// File: rtl/acpi_seq_pkg.sv
package acpi_seq_pkg;

  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_ACT   = 2'd1,
    ST_SUSP  = 2'd2,
    ST_SOFF  = 2'd3
  } pwr_state_t;

  localparam int NUM_DUAL = 2;

endpackage

// File: rtl/acpi_seq_sync.sv
module acpi_seq_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst) stg_q <= '0;
    else     stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/acpi_seq_filter.sv
module acpi_seq_filter
  import acpi_seq_pkg::*;
#(
  parameter int FILT_CYC = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       s3,
  input  logic       s5,
  output logic       fire,
  output pwr_state_t req
);

  localparam int TW = $clog2(FILT_CYC + 1);

  logic [TW-1:0] tmr_q;
  logic          ref_q;
  logic          legal;

  always_comb begin
    legal = !(s3 && !s5);
    case ({s3, s5})
      2'b11:   req = ST_ACT;
      2'b01:   req = ST_SUSP;
      2'b00:   req = ST_SOFF;
      default: req = ST_START;
    endcase
  end

  assign fire = legal && (tmr_q == TW'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tmr_q <= '0;
      ref_q <= s3;
    end else if (tmr_q == '0) begin
      if (s3 != ref_q) tmr_q <= TW'(FILT_CYC);
    end else if (tmr_q == TW'(1)) begin
      tmr_q <= '0;
      if (legal) ref_q <= s3;
    end else begin
      tmr_q <= tmr_q - 1'b1;
    end
  end

  // R3: an expiry on the illegal pattern must not report a request
  a_r3_no_fire_on_illegal: assert property (@(posedge clk) disable iff (rst)
    (s3 && !s5) |-> !fire);

endmodule

// File: rtl/acpi_seq_pgtimer.sv
module acpi_seq_pgtimer #(
  parameter int PG_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic pg,
  output logic ready
);

  localparam int CW = $clog2(PG_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run || !pg)        cnt_q <= '0;
    else if (cnt_q != CW'(PG_CYC)) cnt_q <= cnt_q + 1'b1;
  end

  assign ready = (cnt_q == CW'(PG_CYC));

  // R9: readiness is only held while the supply-good flag was seen high
  a_r9_ready_needs_pg: assert property (@(posedge clk) disable iff (rst)
    ready |-> $past(pg && run));

endmodule

// File: rtl/acpi_seq_fsm.sv
module acpi_seq_fsm
  import acpi_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                s3,
  input  logic                s5,
  input  logic [NUM_DUAL-1:0] keep,
  input  logic                shdn,
  input  logic                fire,
  input  pwr_state_t          req,
  input  logic                ready,
  output pwr_state_t          state_q,
  output logic                in_start,
  output logic                in_act,
  output logic                main_sw_q,
  output logic [NUM_DUAL-1:0] dual_on_q,
  output logic                mem_on_q
);

  pwr_state_t          nxt;
  logic [1:0]          arm_q;
  logic [NUM_DUAL-1:0] en_lat_q;
  logic                capture;
  logic                run_ok;

  always_comb begin
    nxt = state_q;
    if (shdn) begin
      nxt = ST_START;
    end else begin
      case (state_q)
        ST_START: begin
          if (arm_q[1]) begin
            case ({s3, s5})
              2'b11:   nxt = ST_ACT;
              2'b01:   nxt = ST_SUSP;
              2'b00:   nxt = ST_SOFF;
              default: nxt = ST_START;
            endcase
          end
        end
        ST_ACT: begin
          if (fire && req != ST_ACT && req != ST_START)
            nxt = ready ? req : ST_START;
        end
        default: begin
          if (fire && req == ST_ACT) nxt = ST_ACT;
        end
      endcase
    end
  end

  assign capture = (state_q == ST_START) ||
                   (state_q == ST_ACT && (nxt == ST_SUSP || nxt == ST_SOFF));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_START;
      arm_q    <= '0;
      en_lat_q <= '0;
    end else begin
      state_q <= nxt;
      arm_q   <= {arm_q[0], 1'b1};
      if (capture) en_lat_q <= keep;
    end
  end

  assign in_start = (state_q == ST_START);
  assign in_act   = (state_q == ST_ACT);
  assign run_ok   = in_act && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      main_sw_q <= 1'b0;
      mem_on_q  <= 1'b0;
    end else begin
      main_sw_q <= run_ok;
      mem_on_q  <= run_ok || (state_q == ST_SUSP);
    end
  end

  for (genvar g = 0; g < NUM_DUAL; g++) begin : g_dual
    always_ff @(posedge clk) begin
      if (rst) dual_on_q[g] <= 1'b0;
      else     dual_on_q[g] <= run_ok || (state_q == ST_SUSP) ||
                               (state_q == ST_SOFF && en_lat_q[g]);
    end
  end

  // R2: leaving a settled state needs a timer expiry or shutdown
  a_r2_move_needs_fire: assert property (@(posedge clk) disable iff (rst)
    (state_q != $past(state_q) && $past(state_q) != ST_START) |-> $past(fire || shdn));

  // R4: no direct sleep-to-sleep moves
  a_r4_no_susp_to_soff: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == ST_SUSP) |-> (state_q != ST_SOFF));
  a_r4_no_soff_to_susp: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == ST_SOFF) |-> (state_q != ST_SUSP));

  // R6: captured enables hold while asleep
  a_r6_enables_frozen: assert property (@(posedge clk) disable iff (rst)
    (($past(state_q) == ST_SUSP || $past(state_q) == ST_SOFF) && $stable(state_q))
    |-> $stable(en_lat_q));

  // R8: memory rail on implies both dual rails on
  a_r8_mem_implies_duals: assert property (@(posedge clk) disable iff (rst)
    mem_on_q |-> (&dual_on_q));

  // R9: main pass enable only follows a running state
  a_r9_sw_only_running: assert property (@(posedge clk) disable iff (rst)
    main_sw_q |-> $past(state_q == ST_ACT));

  // R11: shutdown forces start-up state
  a_r11_shdn_forces_start: assert property (@(posedge clk) disable iff (rst)
    $past(shdn) |-> (state_q == ST_START));

endmodule

// File: rtl/acpi_sleep_ctl.sv
module acpi_sleep_ctl
  import acpi_seq_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int FILT_US  = 200,
  parameter int PG_MS    = 50,
  parameter int SYNC_STG = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slp3_n_i,
  input  logic       slp5_n_i,
  input  logic       keep3_i,
  input  logic       keep5_i,
  input  logic       pg12_i,
  input  logic       shdn_i,
  output logic [1:0] state_o,
  output logic       main_sw_en_o,
  output logic       dual3_on_o,
  output logic       dual5_on_o,
  output logic       mem_on_o
);

  localparam int FILT_CYC = CLK_HZ / 1_000_000 * FILT_US;
  localparam int PG_CYC   = CLK_HZ / 1000 * PG_MS;
  localparam int NSYNC    = 6;

  logic [NSYNC-1:0]    raw, syn;
  logic                s3, s5, pg, shdn;
  logic [NUM_DUAL-1:0] keep;
  logic                fire, ready, in_start, in_act;
  pwr_state_t          req, state_q;
  logic [NUM_DUAL-1:0] dual_on;

  assign raw = {shdn_i, pg12_i, keep5_i, keep3_i, slp5_n_i, slp3_n_i};

  acpi_seq_sync #(.W(NSYNC), .STAGES(SYNC_STG)) u_sync (
    .clk (clk), .rst (rst), .d (raw), .q (syn)
  );

  assign s3   = syn[0];
  assign s5   = syn[1];
  assign keep = syn[3:2];
  assign pg   = syn[4];
  assign shdn = syn[5];

  acpi_seq_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk (clk), .rst (rst), .clr (in_start),
    .s3 (s3), .s5 (s5), .fire (fire), .req (req)
  );

  acpi_seq_pgtimer #(.PG_CYC(PG_CYC)) u_pg (
    .clk (clk), .rst (rst), .run (in_act), .pg (pg), .ready (ready)
  );

  acpi_seq_fsm u_fsm (
    .clk (clk), .rst (rst), .s3 (s3), .s5 (s5), .keep (keep), .shdn (shdn),
    .fire (fire), .req (req), .ready (ready),
    .state_q (state_q), .in_start (in_start), .in_act (in_act),
    .main_sw_q (main_sw_en_o), .dual_on_q (dual_on), .mem_on_q (mem_on_o)
  );

  assign state_o    = state_q;
  assign dual3_on_o = dual_on[0];
  assign dual5_on_o = dual_on[1];

endmodule

// File: tb/acpi_sleep_ctl_tb.sv
module acpi_sleep_ctl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1_000_000;
  localparam int FILT_US    = 8;
  localparam int PG_MS      = 1;
  localparam int FILT       = CLK_HZ / 1_000_000 * FILT_US;
  localparam int PGC        = CLK_HZ / 1000 * PG_MS;

  logic clk = 1'b0, rst = 1'b1;
  logic s3 = 1'b1, s5 = 1'b0, k3 = 1'b0, k5 = 1'b0, pg = 1'b0, sd = 1'b0;
  logic [1:0] state_o;
  logic sw_o, d3_o, d5_o, mem_o;

  int  n_run = 0, n_fail = 0;
  bit  done = 0, mon = 0, seen0 = 0;

  acpi_sleep_ctl #(.CLK_HZ(CLK_HZ), .FILT_US(FILT_US), .PG_MS(PG_MS)) dut_i (
    .clk (clk), .rst (rst), .slp3_n_i (s3), .slp5_n_i (s5),
    .keep3_i (k3), .keep5_i (k5), .pg12_i (pg), .shdn_i (sd),
    .state_o (state_o), .main_sw_en_o (sw_o), .dual3_on_o (d3_o),
    .dual5_on_o (d5_o), .mem_on_o (mem_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (mon && state_o == 2'd0) seen0 = 1;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [5:0] expv(input int st, input bit rdy, input bit e3, input bit e5);
    bit run = (st == 1) && rdy;
    return {2'(st), run, run || st == 2 || (st == 3 && e3),
            run || st == 2 || (st == 3 && e5), run || st == 2};
  endfunction

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int outv();
    return int'({state_o, sw_o, d3_o, d5_o, mem_o});
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state with illegal lines present
    cyc(5);
    chk("R1", "outputs in reset", outv(), expv(0, 0, 0, 0));
    rst = 1'b0;
    cyc(20);
    chk("R3", "illegal lines at start-up hold state 0", outv(), expv(0, 0, 0, 0));
    s5 = 1'b1;
    cyc(10);
    chk("R1", "start-up leaves to running", outv(), expv(1, 0, 0, 0));
    cyc(2000);
    chk("R9", "no supply good, still off", outv(), expv(1, 0, 0, 0));
    pg = 1'b1;
    cyc(PGC - 5);
    chk("R9", "just before ready", outv(), expv(1, 0, 0, 0));
    cyc(15);
    chk("R9", "ready after timeout", outv(), expv(1, 1, 0, 0));

    // R3: illegal pattern while running
    s5 = 1'b0;
    cyc(50);
    chk("R3", "illegal pattern while running", outv(), expv(1, 1, 0, 0));
    s5 = 1'b1;
    cyc(20);

    // R2: short S3 pulse
    s3 = 1'b0; cyc(3); s3 = 1'b1;
    cyc(30);
    chk("R2", "short S3 pulse ignored", outv(), expv(1, 1, 0, 0));

    // R7 R8 R5 R6: sweep the captured enables
    for (int e = 0; e < 4; e++) begin
      bit e3 = e[0], e5 = e[1];
      k3 = e3; k5 = e5;
      cyc(5);
      mon = 0; seen0 = 0; mon = 1;
      s3 = 1'b0;
      cyc(FILT);
      chk("R2", "no move before expiry", int'(state_o), 1);
      cyc(12);
      chk("R8", "suspend rails", outv(), expv(2, 0, e3, e5));
      chk("R10", "ready request skips state 0", int'(seen0), 0);
      mon = 0;
      s3 = 1'b1;
      cyc(20);
      chk("R9", "back to running, not ready", outv(), expv(1, 0, e3, e5));
      cyc(PGC + 20);
      s3 = 1'b0; cyc(4); s5 = 1'b0;
      cyc(30);
      chk("R5", "S5 within window gives soft-off", int'(state_o), 3);
      chk("R7", "soft-off rails follow enables", outv(), expv(3, 0, e3, e5));
      k3 = !e3; k5 = !e5;
      cyc(30);
      chk("R6", "enable change asleep ignored", outv(), expv(3, 0, e3, e5));
      s5 = 1'b1; cyc(2); s3 = 1'b1;
      cyc(30);
      chk("R7", "wake from soft-off", int'(state_o), 1);
      cyc(PGC + 20);
      chk("R9", "ready again", outv(), expv(1, 1, 0, 0));
    end

    // R5 R4: S5 too late, then a blocked sleep-to-sleep request
    s3 = 1'b0;
    cyc(30);
    s5 = 1'b0;
    cyc(30);
    chk("R5", "late S5 stays suspend", int'(state_o), 2);
    s3 = 1'b1; cyc(3); s3 = 1'b0;
    cyc(30);
    chk("R4", "suspend to soft-off blocked", int'(state_o), 2);
    s5 = 1'b1; s3 = 1'b1;
    cyc(30);
    cyc(PGC + 20);
    chk("R9", "running before soft-off test", outv(), expv(1, 1, 0, 0));

    // R4: soft-off to suspend blocked
    k3 = 1'b1; k5 = 1'b1;
    cyc(5);
    s3 = 1'b0; s5 = 1'b0;
    cyc(30);
    chk("R7", "soft-off with both kept", outv(), expv(3, 0, 1, 1));
    s5 = 1'b1;
    cyc(30);
    s3 = 1'b1; cyc(3); s3 = 1'b0;
    cyc(30);
    chk("R4", "soft-off to suspend blocked", int'(state_o), 3);

    // R11: shutdown and re-capture
    sd = 1'b1;
    cyc(10);
    chk("R11", "shutdown outputs", outv(), expv(0, 0, 0, 0));
    k3 = 1'b0; s5 = 1'b0;
    cyc(10);
    sd = 1'b0;
    cyc(20);
    chk("R11", "release recaptures enables", outv(), expv(3, 0, 0, 1));

    // R10: sleep request before ready
    pg = 1'b0;
    s5 = 1'b1; s3 = 1'b1;
    cyc(30);
    chk("R9", "running without supply good", outv(), expv(1, 0, 0, 1));
    mon = 0; seen0 = 0; mon = 1;
    s3 = 1'b0;
    cyc(30);
    mon = 0;
    chk("R10", "early request passes state 0", int'(seen0), 1);
    chk("R10", "early request ends in suspend", outv(), expv(2, 0, 0, 1));

    done = 1;
    summary();
    $finish;
  end

endmodule